// File: doc/BRIEF.md
# Oscillator-Driven Quadrature Mixer

This block shifts sampled I/Q data in frequency. A 32-bit phase accumulator advances by a programmed step each clock, so the oscillator runs at step × f_clk / 2^32. The top bits of the phase select a cosine and a sine coefficient from a quarter-wave table. The table is computed when the design is elaborated, and quadrant folding builds the full waves from it. The mixer multiplies the registered input pair by these coefficients. It then rounds and saturates the result back to the input width.

Three mixing arrangements can be selected. The first takes a complex input and produces a single real output. The second takes a complex input and produces a complex output, which lets a step word in the upper half of the range act as a negative frequency. The third treats the two inputs as independent real channels. This last arrangement is only meaningful when the oscillator runs at half the sample clock, where the cosine alternates between +1 and −1 and the sine is zero. Any other step word in that arrangement raises a sticky configuration error. A one-bit write port loads either the step word or the arrangement. A separate clear input returns the phase to zero so several instances can be aligned.

Top module: `nco_mixer`

## Requirements
- R1: While reset is held and after it is released, out_i, out_q and cfg_err read 0. The phase accumulator, step word and arrangement code also start at 0, so the arrangement starts as real-out.
- R2: The phase register advances by the step word on every clock. A step-word write changes the increment from the next clock onward and does not disturb the accumulated phase.
- R3: With sync_clr high at a clock edge, the phase becomes 0 at that edge. The next sample is mixed with cosine = +A and sine = 0.
- R4: The coefficient amplitude A is 2^(CW−1)−1 (32767 at defaults). Phase bits [31:30] give the quadrant. At exact quadrant boundaries the coefficient pairs (cos, sin) are (+A,0) at quadrant 0, (0,+A) at quadrant 1, (−A,0) at quadrant 2 and (0,−A) at quadrant 3.
- R5: Arrangement code 0 (real-out): out_i = I·cos − Q·sin and out_q = 0.
- R6: Arrangement code 1 (complex-out): out_i = I·cos − Q·sin and out_q = I·sin + Q·cos. A step word of 2^32−k rotates the same as a step of −k.
- R7: Arrangement code 2 (dual-real): out_i = I·cos and out_q = Q·cos. The sine is not used.
- R8: cfg_err rises one clock after the arrangement is dual-real while the step word differs from 0x8000_0000. It stays high until reset, even after the configuration is corrected. With step 0x8000_0000 it stays low.
- R9: Each output is computed as (sum + 2^(CW−2)) arithmetically shifted right by CW−1. The result is saturated to the range [−2^(DW−1), 2^(DW−1)−1].
- R10: Outputs appear two clocks after the inputs are presented. They use the phase the accumulator held when the inputs were captured.
- R11: A write of arrangement code 3 is ignored, and the previous arrangement stays in force.
- R12: cfg_we with cfg_sel = 0 loads cfg_wdata as the step word. cfg_we with cfg_sel = 1 loads cfg_wdata[1:0] as the arrangement code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the step word, 1 selects the arrangement code |
| cfg_wdata | input | 32 | Configuration write data |
| sync_clr | input | 1 | Clears the phase accumulator |
| in_i | input | 16 | Signed in-phase input sample |
| in_q | input | 16 | Signed quadrature input sample |
| out_i | output | 16 | Signed first output |
| out_q | output | 16 | Signed second output |
| cfg_err | output | 1 | Sticky invalid dual-real configuration flag |

## Verification
The bench steps the oscillator through quarter-turn, negative quarter-turn, eighth-turn and half-rate step words. It checks every sample whose coefficients are exact, so a swapped sine and cosine, a wrong quadrant sign or a wrong sign on the Q path produces wrong outputs at once. Inputs just above half scale expose rounding that truncates or rounds the wrong way. Full-scale opposite-signed inputs at 45° expose a missing or wrapping saturation. A write of the reserved arrangement code checks that the arrangement is not corrupted. A bad half-rate configuration that is later corrected must leave the error flag set, and a design that cleared it would be caught there. The phase clear and a mid-run step change check that a design which reset the phase on a step write, or which misaligned the phase against the two-clock data path, would show as a one-sample slip.

// File: rtl/nco_mixer_pkg.sv
package nco_mixer_pkg;

  typedef enum logic [1:0] {
    MIX_REAL = 2'd0,
    MIX_CPLX = 2'd1,
    MIX_DUAL = 2'd2
  } mix_mode_e;

  localparam logic [1:0] MIX_RSVD = 2'd3;

  localparam logic CFG_SEL_STEP = 1'b0;
  localparam logic CFG_SEL_MODE = 1'b1;

endpackage

// File: rtl/nco_rst_sync.sv
module nco_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sn
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sn = sync_q[1];

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int PW = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_we,
  input  logic [PW-1:0] step_wdata,
  input  logic          sync_clr,
  output logic [PW-1:0] step_o,
  output logic [AW-1:0] addr_o
);

  logic [PW-1:0] step_d, step_q;
  logic [PW-1:0] phase_d, phase_q;

  always_comb begin
    step_d  = step_q;
    if (step_we) begin
      step_d = step_wdata;
    end
    phase_d = sync_clr ? '0 : phase_q + step_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q  <= '0;
      phase_q <= '0;
    end else begin
      if (step_we) begin
        step_q <= step_d;
      end
      phase_q <= phase_d;
    end
  end

  assign step_o = step_q;
  assign addr_o = phase_q[PW-1 -: AW];

  // R3
  phase_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clr |=> (phase_q == '0));

  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_clr |=> (phase_q == $past(phase_q) + $past(step_q)));

endmodule

// File: rtl/nco_sincos_lut.sv
module nco_sincos_lut #(
  parameter int AW = 8,
  parameter int CW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        addr_i,
  output logic signed [CW-1:0] cos_o,
  output logic signed [CW-1:0] sin_o
);

  localparam int QW  = AW - 2;
  localparam int QN  = 1 << QW;
  localparam longint AMP = (longint'(1) << (CW - 1)) - 1;

  // Rational sine approximation over a half turn of 2*QN units; exact at 0 and QN.
  function automatic logic signed [CW-1:0] quarter_val(input int u);
    longint n, t, num, den, v;
    n   = longint'(QN);
    t   = longint'(u) * (2 * n - longint'(u));
    num = 16 * t;
    den = 20 * n * n - 4 * t;
    v   = (AMP * num) / den;
    return v[CW-1:0];
  endfunction

  logic signed [CW-1:0] qtab [0:QN];

  for (genvar g = 0; g <= QN; g++) begin : g_tab
    localparam logic signed [CW-1:0] ENTRY = quarter_val(g);
    assign qtab[g] = ENTRY;
  end

  logic [1:0]           quad;
  logic [QW:0]          ia, ib;
  logic signed [CW-1:0] sin_mag, cos_mag;
  logic                 sin_neg, cos_neg;
  logic signed [CW-1:0] sin_d, cos_d, sin_q, cos_q;

  always_comb begin
    quad    = addr_i[AW-1 -: 2];
    ia      = {1'b0, addr_i[QW-1:0]};
    ib      = (QW+1)'(QN) - ia;
    sin_mag = quad[0] ? qtab[ib] : qtab[ia];
    cos_mag = quad[0] ? qtab[ia] : qtab[ib];
    sin_neg = quad[1];
    cos_neg = quad[1] ^ quad[0];
    sin_d   = sin_neg ? -sin_mag : sin_mag;
    cos_d   = cos_neg ? -cos_mag : cos_mag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sin_q <= '0;
      cos_q <= '0;
    end else begin
      sin_q <= sin_d;
      cos_q <= cos_d;
    end
  end

  assign sin_o = sin_q;
  assign cos_o = cos_q;

  // R4
  lut_axis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i[QW-1:0] == '0) |=> ((cos_q == '0) || (sin_q == '0)));

  // R4
  lut_zero_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == '0) |=> (cos_q == CW'(AMP)) && (sin_q == '0));

endmodule

// File: rtl/nco_mix_core.sv
module nco_mix_core
  import nco_mixer_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  mix_mode_e            mode_i,
  input  logic signed [CW-1:0] cos_i,
  input  logic signed [CW-1:0] sin_i,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);

  localparam int PWD = DW + CW;
  localparam int SW  = PWD + 1;
  localparam logic signed [SW-1:0] RND  = SW'(1) << (CW - 2);
  localparam logic signed [SW-1:0] MAXV = (SW'(1) << (DW - 1)) - SW'(1);
  localparam logic signed [SW-1:0] MINV = -(SW'(1) << (DW - 1));

  function automatic logic signed [DW-1:0] rnd_sat(input logic signed [SW-1:0] x);
    logic signed [SW-1:0] r;
    r = (x + RND) >>> (CW - 1);
    if (r > MAXV) begin
      r = MAXV;
    end else if (r < MINV) begin
      r = MINV;
    end
    return r[DW-1:0];
  endfunction

  // stage 1: capture samples and arrangement alongside the coefficient lookup
  logic signed [DW-1:0] i_s1, q_s1;
  mix_mode_e            mode_s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_s1    <= '0;
      q_s1    <= '0;
      mode_s1 <= MIX_REAL;
    end else begin
      i_s1    <= in_i;
      q_s1    <= in_q;
      mode_s1 <= mode_i;
    end
  end

  logic signed [PWD-1:0] p_ic, p_qs, p_is, p_qc;
  logic signed [SW-1:0]  sum_a, sum_b;
  logic signed [DW-1:0]  oi_d, oq_d, oi_q, oq_q;

  always_comb begin
    p_ic = PWD'(i_s1) * PWD'(cos_i);
    p_qs = PWD'(q_s1) * PWD'(sin_i);
    p_is = PWD'(i_s1) * PWD'(sin_i);
    p_qc = PWD'(q_s1) * PWD'(cos_i);
    unique case (mode_s1)
      MIX_CPLX: begin
        sum_a = SW'(p_ic) - SW'(p_qs);
        sum_b = SW'(p_is) + SW'(p_qc);
      end
      MIX_DUAL: begin
        sum_a = SW'(p_ic);
        sum_b = SW'(p_qc);
      end
      default: begin
        sum_a = SW'(p_ic) - SW'(p_qs);
        sum_b = '0;
      end
    endcase
    oi_d = rnd_sat(sum_a);
    oq_d = rnd_sat(sum_b);
  end

  // stage 2: rounded, saturated outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oi_q <= '0;
      oq_q <= '0;
    end else begin
      oi_q <= oi_d;
      oq_q <= oq_d;
    end
  end

  assign out_i = oi_q;
  assign out_q = oq_q;

  // R5
  real_q_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_s1 == MIX_REAL) |=> (oq_q == '0));

  // R7
  dual_no_sine_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_s1 == MIX_DUAL && cos_i == '0) |=> (oi_q == '0) && (oq_q == '0));

endmodule

// File: rtl/nco_mixer.sv
module nco_mixer
  import nco_mixer_pkg::*;
#(
  parameter int DW = 16,
  parameter int PW = 32,
  parameter int AW = 8,
  parameter int CW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic                 cfg_sel,
  input  logic [PW-1:0]        cfg_wdata,
  input  logic                 sync_clr,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q,
  output logic                 cfg_err
);

  localparam logic [PW-1:0] HALF_STEP = PW'(1) << (PW - 1);

  logic rst_sn;

  nco_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_sn (rst_sn)
  );

  // configuration decode
  logic      step_we, mode_we;
  mix_mode_e mode_d, mode_q;
  logic      err_d, err_q;
  logic [PW-1:0] step_cur;

  always_comb begin
    step_we = cfg_we && (cfg_sel == CFG_SEL_STEP);
    mode_we = cfg_we && (cfg_sel == CFG_SEL_MODE) && (cfg_wdata[1:0] != MIX_RSVD);
    mode_d  = mode_q;
    if (mode_we) begin
      mode_d = mix_mode_e'(cfg_wdata[1:0]);
    end
    err_d = err_q | ((mode_q == MIX_DUAL) && (step_cur != HALF_STEP));
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      mode_q <= MIX_REAL;
      err_q  <= 1'b0;
    end else begin
      if (mode_we) begin
        mode_q <= mode_d;
      end
      err_q <= err_d;
    end
  end

  logic [AW-1:0]        addr;
  logic signed [CW-1:0] cos_c, sin_c;

  nco_phase_acc #(.PW(PW), .AW(AW)) u_acc (
    .clk        (clk),
    .rst_n      (rst_sn),
    .step_we    (step_we),
    .step_wdata (cfg_wdata),
    .sync_clr   (sync_clr),
    .step_o     (step_cur),
    .addr_o     (addr)
  );

  nco_sincos_lut #(.AW(AW), .CW(CW)) u_lut (
    .clk    (clk),
    .rst_n  (rst_sn),
    .addr_i (addr),
    .cos_o  (cos_c),
    .sin_o  (sin_c)
  );

  nco_mix_core #(.DW(DW), .CW(CW)) u_mix (
    .clk    (clk),
    .rst_n  (rst_sn),
    .in_i   (in_i),
    .in_q   (in_q),
    .mode_i (mode_q),
    .cos_i  (cos_c),
    .sin_i  (sin_c),
    .out_i  (out_i),
    .out_q  (out_q)
  );

  assign cfg_err = err_q;

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    cfg_err |=> cfg_err);

  // R8
  err_raise_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (mode_q == MIX_DUAL && step_cur != HALF_STEP) |=> cfg_err);

  // R11
  mode_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (cfg_we && cfg_sel && cfg_wdata[1:0] == MIX_RSVD) |=> $stable(mode_q));

endmodule

// File: tb/nco_mixer_tb.sv
module nco_mixer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam longint AMP = 32767;

  logic                 clk, rst_n, cfg_we, cfg_sel, sync_clr;
  logic [31:0]          cfg_wdata;
  logic signed [DW-1:0] in_i, in_q, out_i, out_q;
  logic                 cfg_err;

  nco_mixer u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .sync_clr  (sync_clr),
    .in_i      (in_i),
    .in_q      (in_q),
    .out_i     (out_i),
    .out_q     (out_q),
    .cfg_err   (cfg_err)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  typedef struct {
    int    ei;
    int    eq;
    bit    ci;
    bit    cq;
    string tag;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0;
  int          n_bad = 0;
  logic [31:0] m_ph, m_fr;
  int          m_md;

  task automatic check_val(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int rs(input longint x);
    longint r;
    r = (x + 16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  // scoreboard monitor: result of item k is visible after edge k+1
  initial begin
    forever begin
      exp_t e;
      @(posedge clk);
      #2;
      if (sb.size() >= 2) begin
        e = sb.pop_front();
        if (e.ci) check_val(e.tag, "out_i", int'(out_i), e.ei);
        if (e.cq) check_val(e.tag, "out_q", int'(out_q), e.eq);
      end
    end
  end

  // driver: drive one sample and push its expected result from the model
  task automatic step(input int i, input int q, input bit clr, input bit we,
                      input bit sel, input logic [31:0] wd, input string tag);
    exp_t   e;
    longint c, s;
    @(negedge clk);
    in_i = DW'(i); in_q = DW'(q);
    sync_clr = clr; cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    e.tag = tag; e.ci = 0; e.cq = 0; e.ei = 0; e.eq = 0;
    if (m_ph[29:0] == 30'd0) begin
      case (m_ph[31:30])
        2'd0: begin c = AMP;  s = 0;    end
        2'd1: begin c = 0;    s = AMP;  end
        2'd2: begin c = -AMP; s = 0;    end
        default: begin c = 0; s = -AMP; end
      endcase
      e.ci = 1; e.cq = 1;
      case (m_md)
        1: begin e.ei = rs(i*c - q*s); e.eq = rs(i*s + q*c); end
        2: begin e.ei = rs(i*c);       e.eq = rs(q*c);       end
        default: begin e.ei = rs(i*c - q*s); e.eq = 0; end
      endcase
    end else begin
      if (m_md == 0) begin e.cq = 1; e.eq = 0; end
      if (m_md == 0 && i == 32767 && q == -32768) begin
        if (m_ph == 32'h2000_0000) begin e.ci = 1; e.ei = 32767;  end
        if (m_ph == 32'hA000_0000) begin e.ci = 1; e.ei = -32768; end
      end
    end
    sb.push_back(e);
    if (clr) m_ph = 32'd0;
    else     m_ph = m_ph + m_fr;
    if (we) begin
      if (sel == 1'b0) m_fr = wd;
      else if (wd[1:0] != 2'd3) m_md = int'(wd[1:0]);
    end
  endtask

  task automatic idle(input int i, input int q, input string tag);
    step(i, q, 1'b0, 1'b0, 1'b0, 32'd0, tag);
  endtask

  task automatic wr(input bit sel, input logic [31:0] wd, input string tag);
    step(1234, -4321, 1'b0, 1'b1, sel, wd, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL R10 watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; sync_clr = 0;
    in_i = '0; in_q = '0;
    m_ph = 0; m_fr = 0; m_md = 0;
    repeat (4) @(negedge clk);
    // R1 during reset
    check_val("R1", "out_i", int'(out_i), 0);
    check_val("R1", "out_q", int'(out_q), 0);
    check_val("R1", "cfg_err", int'(cfg_err), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 after release
    check_val("R1", "out_i", int'(out_i), 0);
    check_val("R1", "cfg_err", int'(cfg_err), 0);

    // R5 real-out at phase 0, step 0
    repeat (3) idle(1000, 500, "R5");
    // R12 step write; R2 phase keeps its value and increments from next clock
    step(12000, -7000, 1'b0, 1'b1, 1'b0, 32'h4000_0000, "R12");
    for (int k = 0; k < 8; k++) idle(3000 + k*1111, -2000 + k*777, "R4");
    // R12 arrangement write: complex-out
    wr(1'b1, 32'd1, "R12");
    for (int k = 0; k < 8; k++) idle(-9000 + k*2100, 5000 - k*1300, "R6");
    // R6 negative frequency
    wr(1'b0, 32'hC000_0000, "R6");
    for (int k = 0; k < 8; k++) idle(7000 - k*900, 1500 + k*400, "R6");
    // R2 step change mid-run without phase reset
    wr(1'b0, 32'h4000_0000, "R2");
    for (int k = 0; k < 4; k++) idle(2500, -2500 + k*1000, "R2");
    // R3 phase clear
    step(20000, -20000, 1'b1, 1'b0, 1'b0, 32'd0, "R3");
    for (int k = 0; k < 4; k++) idle(11000, 6000, "R3");
    // R9 rounding near half scale and at full scale
    for (int k = 0; k < 4; k++) idle(16385, -16385, "R9");
    for (int k = 0; k < 4; k++) idle(-32768, 32767, "R9");
    // R11 reserved code ignored, arrangement stays complex-out
    wr(1'b1, 32'd3, "R11");
    for (int k = 0; k < 4; k++) idle(4000, -3000, "R11");
    // R9 saturation at 45 deg in real-out
    wr(1'b1, 32'd0, "R5");
    wr(1'b0, 32'h2000_0000, "R9");
    step(0, 0, 1'b1, 1'b0, 1'b0, 32'd0, "R3");
    for (int k = 0; k < 9; k++) idle(32767, -32768, "R9");
    // R7 dual-real at half rate, no error
    wr(1'b0, 32'h8000_0000, "R7");
    wr(1'b1, 32'd2, "R7");
    step(0, 0, 1'b1, 1'b0, 1'b0, 32'd0, "R7");
    for (int k = 0; k < 6; k++) idle(5000 + k*3000, -8000 + k*1700, "R7");
    check_val("R8", "cfg_err", int'(cfg_err), 0);
    // R10 impulse latency
    idle(0, 0, "R10");
    idle(9000, -9000, "R10");
    idle(0, 0, "R10");
    idle(0, 0, "R10");
    // R8 bad half-rate configuration, then corrected
    wr(1'b0, 32'h4000_0000, "R8");
    idle(0, 0, "R8");
    idle(0, 0, "R8");
    check_val("R8", "cfg_err", int'(cfg_err), 1);
    wr(1'b0, 32'h8000_0000, "R8");
    for (int k = 0; k < 3; k++) idle(100, 200, "R8");
    check_val("R8", "cfg_err", int'(cfg_err), 1);
    idle(0, 0, "R7");
    idle(0, 0, "R7");
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule